// File: doc/BRIEF.md
# AES Column Mixer with Shared Forward Network

This block transforms one 32-bit AES state column in a single pass. With the mode bit low it applies the forward column mixing used in encryption. With the mode bit high it applies the inverse mixing used in decryption. The inverse is not built from a separate network with the heavy constants 09, 0B, 0D and 0E. Instead the column first goes through a light pre-scaling matrix whose largest constant is 05. The result then enters the same forward network that encryption uses. All arithmetic is in GF(2^8) with the reduction polynomial x^8+x^4+x^3+x+1.

A column is offered together with a valid strobe and a mode bit. The transformed column appears on a registered output one clock later, together with a registered valid. The surrounding datapath owns the full state, the row rotation and the key addition. This unit only sees one column at a time, and it accepts a new column on every cycle.

Top module: `mix_column_unit`

## Requirements
- R1: While rst_n is low, and after it is released until the first accepted column, res_valid is 0 and res_col is 32'h0.
- R2: Byte 0 of a column sits in bits [31:24] and byte 3 in bits [7:0]. In forward mode (col_inv=0) the column 32'hdb135345 gives 32'h8e4da1bc.
- R3: In forward mode each output byte is y_i = 02·a_i ^ 03·a_(i+1) ^ a_(i+2) ^ a_(i+3), with indices taken mod 4.
- R4: In inverse mode (col_inv=1) each output byte is y_i = 0E·a_i ^ 0B·a_(i+1) ^ 0D·a_(i+2) ^ 09·a_(i+3). This makes the inverse of a forward result equal to the original column.
- R5: In inverse mode, 32'h8e4da1bc gives 32'hdb135345.
- R6: A column presented with col_valid=1 at a rising edge appears on res_col at that edge, and res_valid is 1 for exactly the cycle after each accepted column. Back-to-back columns in mixed modes are accepted on consecutive cycles.
- R7: While col_valid is 0, res_col keeps its last value and res_valid is 0, whatever col_in and col_inv carry.
- R8: A column whose four bytes are equal passes through unchanged in both modes.
- R9: In both modes the XOR of the four output bytes equals the XOR of the four input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| col_valid | input | 1 | Column on col_in is to be transformed this cycle |
| col_inv | input | 1 | 0 selects forward mixing, 1 selects inverse mixing |
| col_in | input | 32 | Input column, byte 0 in bits [31:24] |
| res_valid | output | 1 | res_col holds a newly transformed column |
| res_col | output | 32 | Transformed column, registered |

## Verification
The output register is the only state, so a wrong value in it shows at res_col one cycle after the column that caused it. A defect in the pre-scaling matrix or in the mode select shows only in inverse mode, as a wrong inverse result or a failed round trip. A defect in the shared forward network shows in both modes. Wrong load enables show as a changed res_col or a stray res_valid during idle cycles. Wrong byte rotations break the published test column and the round trip within one transaction.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  function automatic logic [BYTE_W-1:0] gf_x2(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x3(input logic [BYTE_W-1:0] a);
    return gf_x2(a) ^ a;
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x4(input logic [BYTE_W-1:0] a);
    return gf_x2(gf_x2(a));
  endfunction

  function automatic logic [BYTE_W-1:0] gf_x5(input logic [BYTE_W-1:0] a);
    return gf_x4(a) ^ a;
  endfunction

  function automatic logic [BYTE_W-1:0] byte_fold(input logic [COL_W-1:0] c);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < COL_BYTES; k++) acc ^= c[k*BYTE_W +: BYTE_W];
    return acc;
  endfunction
endpackage

// File: rtl/mc_prescale.sv
module mc_prescale
  import mixcol_pkg::*;
(
  input  logic [COL_W-1:0] pre_in,
  output logic [COL_W-1:0] pre_out
);
  logic [BYTE_W-1:0] a_b [COL_BYTES];
  logic [BYTE_W-1:0] p_b [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_lane
    localparam int HI = COL_W - 1 - i * BYTE_W;
    localparam int OPP = (i + 2) % COL_BYTES;
    assign a_b[i] = pre_in[HI -: BYTE_W];
    // circulant row 05 00 04 00
    assign p_b[i] = gf_x5(a_b[i]) ^ gf_x4(a_b[OPP]);
    assign pre_out[HI -: BYTE_W] = p_b[i];
  end
endmodule

// File: rtl/mc_forward.sv
module mc_forward
  import mixcol_pkg::*;
(
  input  logic [COL_W-1:0] fw_in,
  output logic [COL_W-1:0] fw_out
);
  logic [BYTE_W-1:0] b_b [COL_BYTES];
  logic [BYTE_W-1:0] y_b [COL_BYTES];

  for (genvar i = 0; i < COL_BYTES; i++) begin : g_lane
    localparam int HI = COL_W - 1 - i * BYTE_W;
    localparam int N1 = (i + 1) % COL_BYTES;
    localparam int N2 = (i + 2) % COL_BYTES;
    localparam int N3 = (i + 3) % COL_BYTES;
    assign b_b[i] = fw_in[HI -: BYTE_W];
    // circulant row 02 03 01 01
    assign y_b[i] = gf_x2(b_b[i]) ^ gf_x3(b_b[N1]) ^ b_b[N2] ^ b_b[N3];
    assign fw_out[HI -: BYTE_W] = y_b[i];
  end
endmodule

// File: rtl/mix_column_unit.sv
module mix_column_unit
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_valid,
  input  logic             col_inv,
  input  logic [COL_W-1:0] col_in,
  output logic             res_valid,
  output logic [COL_W-1:0] res_col
);
  logic [COL_W-1:0] pre_col;
  logic [COL_W-1:0] fw_src;
  logic [COL_W-1:0] fw_res;
  logic [COL_W-1:0] col_d, col_q;
  logic             vld_d, vld_q;

  mc_prescale u_pre (.pre_in(col_in), .pre_out(pre_col));

  assign fw_src = col_inv ? pre_col : col_in;

  mc_forward u_fwd (.fw_in(fw_src), .fw_out(fw_res));

  always_comb begin
    vld_d = col_valid;
    col_d = col_q;
    if (col_valid) col_d = fw_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      col_q <= '0;
    end else begin
      vld_q <= vld_d;
      col_q <= col_d;
    end
  end

  assign res_valid = vld_q;
  assign res_col   = col_q;

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> res_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |=> (!res_valid && $stable(res_col)));

  // R8
  uniform_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_in == {COL_BYTES{col_in[BYTE_W-1:0]}}) |=> res_col == $past(col_in));

  // R9
  fold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> byte_fold(res_col) == byte_fold($past(col_in)));
endmodule

// File: tb/mix_column_unit_bench.sv
module mix_column_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        col_valid;
  logic        col_inv;
  logic [31:0] col_in;
  logic        res_valid;
  logic [31:0] res_col;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  mix_column_unit u_mix_column_unit (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_inv(col_inv),
    .col_in(col_in), .res_valid(res_valid), .res_col(res_col)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] model(input logic inv, input logic [31:0] c);
    logic [7:0] co [4];
    logic [7:0] a [4];
    logic [31:0] r = '0;
    if (inv) begin co[0]=8'h0E; co[1]=8'h0B; co[2]=8'h0D; co[3]=8'h09; end
    else     begin co[0]=8'h02; co[1]=8'h03; co[2]=8'h01; co[3]=8'h01; end
    for (int k = 0; k < 4; k++) a[k] = c[31-8*k -: 8];
    for (int i = 0; i < 4; i++) begin
      logic [7:0] y = 8'h00;
      for (int j = 0; j < 4; j++) y ^= gmul(co[(j - i + 4) % 4], a[j]);
      r[31-8*i -: 8] = y;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, result registered at the posedge, sampled at next negedge.
  task automatic xfer(input logic inv, input logic [31:0] c, output logic [31:0] y);
    col_valid = 1'b1; col_inv = inv; col_in = c;
    @(negedge clk);
    col_valid = 1'b0;
    check("R6 valid", {31'b0, res_valid}, 32'd1);
    y = res_col;
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, res_valid}, 32'd0);
    check("R1 col", res_col, 32'h0);
  endtask

  task automatic t_known;
    logic [31:0] y;
    xfer(1'b0, 32'hdb135345, y); check("R2 forward vector", y, 32'h8e4da1bc);
    xfer(1'b1, 32'h8e4da1bc, y); check("R5 inverse vector", y, 32'hdb135345);
  endtask

  task automatic t_random;
    logic [31:0] c, y, z;
    for (int n = 0; n < 30; n++) begin
      c = $urandom;
      xfer(1'b0, c, y); check("R3 forward", y, model(1'b0, c));
      xfer(1'b1, c, z); check("R4 inverse", z, model(1'b1, c));
      xfer(1'b1, y, z); check("R4 round trip", z, c);
    end
  endtask

  task automatic t_uniform;
    logic [31:0] y;
    for (int n = 0; n < 4; n++) begin
      logic [7:0] v = 8'(n * 85 + 7);
      xfer(1'b0, {4{v}}, y); check("R8 uniform fwd", y, {4{v}});
      xfer(1'b1, {4{v}}, y); check("R8 uniform inv", y, {4{v}});
    end
  endtask

  task automatic t_fold;
    logic [31:0] c, y;
    for (int n = 0; n < 6; n++) begin
      c = $urandom;
      xfer(1'(n & 1), c, y);
      check("R9 byte fold", {24'b0, y[31:24]^y[23:16]^y[15:8]^y[7:0]},
            {24'b0, c[31:24]^c[23:16]^c[15:8]^c[7:0]});
    end
  endtask

  task automatic t_idle;
    logic [31:0] y;
    xfer(1'b0, 32'h01020304, y);
    for (int n = 0; n < 4; n++) begin
      col_valid = 1'b0; col_inv = 1'(n); col_in = $urandom;
      @(negedge clk);
      check("R7 idle valid", {31'b0, res_valid}, 32'd0);
      check("R7 idle hold", res_col, model(1'b0, 32'h01020304));
    end
  endtask

  task automatic t_stream;
    logic [31:0] c [8];
    for (int n = 0; n < 8; n++) c[n] = $urandom;
    col_valid = 1'b1; col_inv = 1'b0; col_in = c[0];
    @(negedge clk);
    for (int n = 1; n < 8; n++) begin
      check("R6 stream valid", {31'b0, res_valid}, 32'd1);
      check("R6 stream data", res_col, model(1'((n - 1) & 1), c[n-1]));
      col_inv = 1'(n & 1); col_in = c[n];
      @(negedge clk);
    end
    col_valid = 1'b0;
    check("R6 stream last", res_col, model(1'b1, c[7]));
    @(negedge clk);
    check("R6 single pulse", {31'b0, res_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; col_valid = 1'b0; col_inv = 1'b0; col_in = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_known;
    t_random;
    t_uniform;
    t_fold;
    t_idle;
    t_stream;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule